// File: doc/BRIEF.md
# Serially Loaded Board Control Register

This block is a 20-bit board control register that a host fills one bit at a time over three slow strobe lines: a data line, a shift strobe and a load strobe. Every rising edge of the shift strobe moves the current data level into a shift register, least-significant bit first. The outputs do not follow the shift register. They change only when the load strobe rises, and that edge copies all 20 shifted bits to the output register at once. A controller can therefore build a complete word without disturbing the board.

The three strobe lines come from another clock domain. Each one passes through a two-stage synchroniser, and edges are found on the synchronised copies. The output word also appears as named control fields: selects and strobes for a serial configuration memory, a serial gain-trim interface, converter calibration, reset and mute controls, an indicator lamp, and two digital-audio source selectors. Several of these controls are active low.

Top module: `serial_ctl_latch`

## Requirements
- R1: The register holds exactly 20 bits, visible as `ctl_word_o[19:0]`.
- R2: Each rising edge of `shift_clk_i` shifts in the level of `ser_data_i` held around that edge. Bits arrive LSB first, so after 20 edges the first bit sent sits in bit 0 and the last in bit 19.
- R3: Shift edges alone never change `ctl_word_o` or any field output.
- R4: A rising edge of `latch_i` copies the whole shift register to the outputs in one step. A second load edge with no shifting in between reproduces the same word.
- R5: Field positions in the word: 0 `ac3_sel_n_o`, 1 `mem_dsel_o`, 2 `mem_csel_n_o`, 3 `mem_clk_o`, 4 `mem_cs_o`, 5 `mem_dout_o`, 6 `trim_cs_n_o`, 7 `trim_sclk_o`, 8 `trim_sdata_o`, 9 `trim_mute_n_o`, 10 `adc_cal_o`, 11 `adc_rst_n_o`, 12 `dac_cal_o`, 13 `dac_mute_n_o`, 14 `led_n_o`. A field ending in `_n` is active low.
- R6: `spdif0_src_o` is bits 16:15 and `spdif1_src_o` is bits 19:17 of the word.
- R7: While `rst_n` is low, the shift register and the output word are both zero, so every active-low control reads asserted.
- R8: If more than 20 bits are shifted before a load, only the last 20 are kept. The oldest kept bit lands in bit 0.
- R9: If a shift edge and a load edge are detected in the same clock cycle, the loaded word already contains the new bit in bit 19, with the older bits moved down by one.
- R10: Outputs change on the third rising `clk` edge after `latch_i` goes high: two cycles of synchronisation and one register stage.
- R11: The run-mode word 0x82A40 reads out as `dac_mute_n_o`, `adc_rst_n_o`, `trim_mute_n_o` and `trim_cs_n_o` high, `spdif0_src_o` = 0, `spdif1_src_o` = 4, and every other field 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_data_i | input | 1 | Serial data line |
| shift_clk_i | input | 1 | Shift strobe, data taken on its rising edge |
| latch_i | input | 1 | Load strobe, rising edge updates outputs |
| ctl_word_o | output | 20 | Whole output word |
| ac3_sel_n_o | output | 1 | Compressed-audio data select, active low |
| mem_dsel_o | output | 1 | Configuration-memory data select |
| mem_csel_n_o | output | 1 | Configuration-memory control select, active low |
| mem_clk_o | output | 1 | Configuration-memory clock |
| mem_cs_o | output | 1 | Configuration-memory chip select |
| mem_dout_o | output | 1 | Configuration-memory serial data |
| trim_cs_n_o | output | 1 | Trim chip select, active low |
| trim_sclk_o | output | 1 | Trim serial clock |
| trim_sdata_o | output | 1 | Trim serial data |
| trim_mute_n_o | output | 1 | Trim mute, active low |
| adc_cal_o | output | 1 | ADC calibrate, inverted sense |
| adc_rst_n_o | output | 1 | ADC reset, active low |
| dac_cal_o | output | 1 | DAC calibrate |
| dac_mute_n_o | output | 1 | DAC mute, active low |
| led_n_o | output | 1 | Indicator lamp, active low |
| spdif0_src_o | output | 2 | Source select for digital output 0 |
| spdif1_src_o | output | 3 | Source select for digital output 1 |

## Verification
The shift and the load can fall in the same clock cycle. The bench provokes this by raising `shift_clk_i` and `latch_i` at the same instant, after a full word has been shifted in with a known new data level. The loaded word must equal the old word moved down by one with the new bit in bit 19. A follow-up load with no shift must return the same word. Walking-one, walking-zero and field-value sweeps check the bit order and the field map, and an overlong burst checks that the oldest bits are dropped.

// File: rtl/serial_ctl_pkg.sv
package serial_ctl_pkg;

  localparam int CTL_W = 20;

  typedef struct packed {
    logic [2:0] spdif1_src;
    logic [1:0] spdif0_src;
    logic       led_n;
    logic       dac_mute_n;
    logic       dac_cal;
    logic       adc_rst_n;
    logic       adc_cal;
    logic       trim_mute_n;
    logic       trim_sdata;
    logic       trim_sclk;
    logic       trim_cs_n;
    logic       mem_dout;
    logic       mem_cs;
    logic       mem_clk;
    logic       mem_csel_n;
    logic       mem_dsel;
    logic       ac3_sel_n;
  } ctl_fields_t;

  localparam logic [CTL_W-1:0] RUN_MODE_WORD = 20'h82A40;

endpackage

// File: rtl/level_sync.sv
module level_sync #(
  parameter int LINES  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] raw_i,
  output logic [LINES-1:0] lvl_o
);

  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic [STAGES-1:0] pipe_q;
    logic [STAGES-1:0] pipe_d;

    always_comb begin
      pipe_d = {pipe_q[STAGES-2:0], raw_i[g]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe_q <= '0;
      else        pipe_q <= pipe_d;
    end

    assign lvl_o[g] = pipe_q[STAGES-1];
  end

endmodule

// File: rtl/rise_detect.sv
module rise_detect #(
  parameter int LINES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] lvl_i,
  output logic [LINES-1:0] rise_o
);

  logic [LINES-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= lvl_i;
  end

  assign rise_o = lvl_i & ~prev_q;

  for (genvar g = 0; g < LINES; g++) begin : g_chk
    // R10: one detected edge gives exactly one cycle of pulse
    p_single_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
      rise_o[g] |=> !rise_o[g]);
  end

endmodule

// File: rtl/ctl_shifter.sv
module ctl_shifter #(
  parameter int WIDTH = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             shift_en_i,
  input  logic             bit_i,
  output logic [WIDTH-1:0] next_o,
  output logic [WIDTH-1:0] q_o
);

  logic [WIDTH-1:0] sr_q;

  always_comb begin
    next_o = sr_q;
    if (shift_en_i) next_o = {bit_i, sr_q[WIDTH-1:1]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          sr_q <= '0;
    else if (shift_en_i) sr_q <= next_o;
  end

  assign q_o = sr_q;

  p_shift_lsb_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en_i |=> (q_o[WIDTH-1] == $past(bit_i)) &&
                   (q_o[WIDTH-2:0] == $past(q_o[WIDTH-1:1])));

  p_shift_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_en_i |=> $stable(q_o));

endmodule

// File: rtl/ctl_holder.sv
module ctl_holder #(
  parameter int WIDTH = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  logic [WIDTH-1:0] hold_q;
  logic [WIDTH-1:0] hold_d;

  always_comb begin
    hold_d = hold_q;
    if (load_i) hold_d = d_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hold_q <= '0;
    else        hold_q <= hold_d;
  end

  assign q_o = hold_q;

  p_hold_without_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !load_i |=> $stable(q_o));

  p_load_copies_r4: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> q_o == $past(d_i));

endmodule

// File: rtl/serial_ctl_latch.sv
module serial_ctl_latch
  import serial_ctl_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ser_data_i,
  input  logic             shift_clk_i,
  input  logic             latch_i,
  output logic [CTL_W-1:0] ctl_word_o,
  output logic             ac3_sel_n_o,
  output logic             mem_dsel_o,
  output logic             mem_csel_n_o,
  output logic             mem_clk_o,
  output logic             mem_cs_o,
  output logic             mem_dout_o,
  output logic             trim_cs_n_o,
  output logic             trim_sclk_o,
  output logic             trim_sdata_o,
  output logic             trim_mute_n_o,
  output logic             adc_cal_o,
  output logic             adc_rst_n_o,
  output logic             dac_cal_o,
  output logic             dac_mute_n_o,
  output logic             led_n_o,
  output logic [1:0]       spdif0_src_o,
  output logic [2:0]       spdif1_src_o
);

  localparam int N_LINES = 3;
  localparam int L_DATA  = 0;
  localparam int L_SHIFT = 1;
  localparam int L_LOAD  = 2;

  logic [N_LINES-1:0] lvl;
  logic [1:0]         rise;
  logic [CTL_W-1:0]   sh_next;
  logic [CTL_W-1:0]   sh_q;
  logic [CTL_W-1:0]   word;
  ctl_fields_t        fld;

  level_sync #(.LINES(N_LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .raw_i ({latch_i, shift_clk_i, ser_data_i}),
    .lvl_o (lvl)
  );

  rise_detect #(.LINES(2)) u_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .lvl_i  (lvl[L_LOAD:L_SHIFT]),
    .rise_o (rise)
  );

  ctl_shifter #(.WIDTH(CTL_W)) u_shift (
    .clk        (clk),
    .rst_n      (rst_n),
    .shift_en_i (rise[0]),
    .bit_i      (lvl[L_DATA]),
    .next_o     (sh_next),
    .q_o        (sh_q)
  );

  ctl_holder #(.WIDTH(CTL_W)) u_hold (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (rise[1]),
    .d_i    (sh_next),
    .q_o    (word)
  );

  assign fld           = ctl_fields_t'(word);
  assign ctl_word_o    = word;
  assign ac3_sel_n_o   = fld.ac3_sel_n;
  assign mem_dsel_o    = fld.mem_dsel;
  assign mem_csel_n_o  = fld.mem_csel_n;
  assign mem_clk_o     = fld.mem_clk;
  assign mem_cs_o      = fld.mem_cs;
  assign mem_dout_o    = fld.mem_dout;
  assign trim_cs_n_o   = fld.trim_cs_n;
  assign trim_sclk_o   = fld.trim_sclk;
  assign trim_sdata_o  = fld.trim_sdata;
  assign trim_mute_n_o = fld.trim_mute_n;
  assign adc_cal_o     = fld.adc_cal;
  assign adc_rst_n_o   = fld.adc_rst_n;
  assign dac_cal_o     = fld.dac_cal;
  assign dac_mute_n_o  = fld.dac_mute_n;
  assign led_n_o       = fld.led_n;
  assign spdif0_src_o  = fld.spdif0_src;
  assign spdif1_src_o  = fld.spdif1_src;

  p_same_cycle_new_bit_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rise[0] && rise[1]) |=> (ctl_word_o[CTL_W-1] == $past(lvl[L_DATA])) &&
                             (ctl_word_o[CTL_W-2:0] == $past(sh_q[CTL_W-1:1])));

  p_load_matches_shifter_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rise[1] && !rise[0]) |=> ctl_word_o == sh_q);

endmodule

// File: tb/test_serial_ctl_latch.sv
module test_serial_ctl_latch;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        ser_data_i, shift_clk_i, latch_i;
  logic [19:0] ctl_word_o;
  logic ac3_sel_n_o, mem_dsel_o, mem_csel_n_o, mem_clk_o, mem_cs_o, mem_dout_o;
  logic trim_cs_n_o, trim_sclk_o, trim_sdata_o, trim_mute_n_o;
  logic adc_cal_o, adc_rst_n_o, dac_cal_o, dac_mute_n_o, led_n_o;
  logic [1:0] spdif0_src_o;
  logic [2:0] spdif1_src_o;

  int n_vec = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  serial_ctl_latch i_serial_ctl_latch (
    .clk(clk), .rst_n(rst_n), .ser_data_i(ser_data_i), .shift_clk_i(shift_clk_i),
    .latch_i(latch_i), .ctl_word_o(ctl_word_o), .ac3_sel_n_o(ac3_sel_n_o),
    .mem_dsel_o(mem_dsel_o), .mem_csel_n_o(mem_csel_n_o), .mem_clk_o(mem_clk_o),
    .mem_cs_o(mem_cs_o), .mem_dout_o(mem_dout_o), .trim_cs_n_o(trim_cs_n_o),
    .trim_sclk_o(trim_sclk_o), .trim_sdata_o(trim_sdata_o),
    .trim_mute_n_o(trim_mute_n_o), .adc_cal_o(adc_cal_o), .adc_rst_n_o(adc_rst_n_o),
    .dac_cal_o(dac_cal_o), .dac_mute_n_o(dac_mute_n_o), .led_n_o(led_n_o),
    .spdif0_src_o(spdif0_src_o), .spdif1_src_o(spdif1_src_o)
  );

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [19:0] got, input logic [19:0] exp);
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%05h expected=%05h", req, got, exp);
    end
  endtask

  function automatic logic [19:0] packed_fields();
    return {spdif1_src_o, spdif0_src_o, led_n_o, dac_mute_n_o, dac_cal_o,
            adc_rst_n_o, adc_cal_o, trim_mute_n_o, trim_sdata_o, trim_sclk_o,
            trim_cs_n_o, mem_dout_o, mem_cs_o, mem_clk_o, mem_csel_n_o,
            mem_dsel_o, ac3_sel_n_o};
  endfunction

  task automatic put_bit(input logic b);
    ser_data_i = b;
    tick(3);
    shift_clk_i = 1'b1;
    tick(3);
    shift_clk_i = 1'b0;
    tick(3);
  endtask

  task automatic put_bits(input logic [31:0] v, input int n);
    for (int i = 0; i < n; i++) put_bit(v[i]);
  endtask

  task automatic do_load();
    latch_i = 1'b1;
    tick(3);
    latch_i = 1'b0;
    tick(3);
  endtask

  // shift a word, check outputs are unchanged (R3), load and check word and fields
  task automatic send_word(input logic [19:0] w, input logic [19:0] prev, input string req);
    put_bits({12'h0, w}, 20);
    chk("R3 outputs before load", ctl_word_o, prev);
    do_load();
    chk(req, ctl_word_o, w);
    chk("R5/R6 field map", packed_fields(), w);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_bad++;
    $display("FAIL watchdog got=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    logic [19:0] last;
    rst_n = 1'b0; ser_data_i = 1'b0; shift_clk_i = 1'b0; latch_i = 1'b0;
    tick(4);
    // R7: reset state, active-low fields asserted
    chk("R7 reset word", ctl_word_o, 20'h0);
    chk("R7 led_n asserted", {19'h0, led_n_o}, 20'h0);
    rst_n = 1'b1;
    tick(2);
    last = 20'h0;

    // R1 R2: walking one, bit order LSB first
    for (int i = 0; i < 20; i++) begin
      send_word(20'h1 << i, last, "R2 walking one");
      last = 20'h1 << i;
    end
    // R1: walking zero
    for (int i = 0; i < 20; i++) begin
      send_word(~(20'h1 << i), last, "R1 walking zero");
      last = ~(20'h1 << i);
    end
    // R6: sweep both source selectors
    for (int a = 0; a < 4; a++)
      for (int b = 0; b < 8; b++) begin
        logic [19:0] w;
        w = {b[2:0], a[1:0], 15'h5A5A ^ 15'(a * 8 + b)};
        send_word(w, last, "R6 selector sweep");
        last = w;
      end

    // R11: run-mode word
    send_word(20'h82A40, last, "R11 run mode word");
    chk("R11 dac_mute_n/adc_rst_n/trim_mute_n/trim_cs_n",
        {16'h0, dac_mute_n_o, adc_rst_n_o, trim_mute_n_o, trim_cs_n_o}, 20'hF);
    chk("R11 selectors", {15'h0, spdif1_src_o, spdif0_src_o}, 20'h10);
    last = 20'h82A40;

    // R4: second load without shifting repeats the word
    do_load();
    chk("R4 repeat load", ctl_word_o, last);

    // R8: 25 bits shifted, only last 20 kept
    begin
      logic [31:0] v;
      v = 32'h1ABCDEF;
      put_bits(v, 25);
      chk("R3 outputs before load", ctl_word_o, last);
      do_load();
      chk("R8 overlong burst", ctl_word_o, v[24:5]);
      last = v[24:5];
    end

    // R10: latency of load edge
    put_bits(32'h000F0F0F, 20);
    latch_i = 1'b1;
    tick(2);
    chk("R10 not yet after two edges", ctl_word_o, last);
    tick(1);
    chk("R10 updated on third edge", ctl_word_o, 20'hF0F0F);
    latch_i = 1'b0;
    tick(3);
    last = 20'hF0F0F;

    // R9: shift and load in the same cycle
    put_bits(32'h00012345, 20);
    ser_data_i = 1'b1;
    tick(3);
    shift_clk_i = 1'b1;
    latch_i = 1'b1;
    tick(3);
    shift_clk_i = 1'b0;
    latch_i = 1'b0;
    tick(3);
    chk("R9 simultaneous shift and load", ctl_word_o, {1'b1, 19'(20'h12345 >> 1)});
    do_load();
    chk("R9 shifter kept new bit", ctl_word_o, {1'b1, 19'(20'h12345 >> 1)});

    // R7: reset mid-operation clears outputs
    rst_n = 1'b0;
    tick(1);
    chk("R7 reset clears word", ctl_word_o, 20'h0);
    rst_n = 1'b1;
    tick(2);
    do_load();
    chk("R7 reset cleared shifter", ctl_word_o, 20'h0);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule